// File: doc/BRIEF.md
# Radix-4 Recoded Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. The multiplier operand is scanned in overlapping three-bit windows, each window choosing one signed digit from {-2, -1, 0, +1, +2}. Each digit selects a row equal to that multiple of the multiplicand, so the block builds about half as many rows as a plain AND array would. A row with a negative digit is formed by inverting the selected bits. The missing +1 for that row goes into a separate correction vector. The sign extension of each row is folded into one inverted sign bit per row plus a single constant that is computed at elaboration time. All rows, the correction vector and the constant are merged by a chain of 3:2 carry-save stages and one carry-propagate adder.

The arithmetic is purely combinational. One register stage sits at the output. The caller presents both operands with `in_valid` high, and the product appears on `out_p` one clock later, qualified by `out_valid`.

Top module: `booth_mult`

## Requirements
- R1: One cycle after a clock edge at which `in_valid` is high, `out_p` equals the full unsigned product `in_x * in_y` of the operands sampled at that edge, with no truncation of the `2*WIDTH`-bit result.
- R2: `out_valid` is high in exactly the cycles that follow an edge at which `in_valid` was high.
- R3: With `rst` high at a clock edge, `out_valid` becomes 0 and `out_p` becomes all zeros after that edge.
- R4: After an edge at which `in_valid` is low, `out_p` keeps the value it had before that edge.
- R5: A zero multiplier `in_x` gives a zero product for any multiplicand.
- R6: A multiplicand `in_y` of 1 gives a product equal to `in_x` zero-extended.
- R7: Both operands all ones give (2^WIDTH-1)^2. For WIDTH=16 this is 0xFFFE0001.
- R8: Multipliers whose windows produce negative digits give exact products. These include alternating bits 1010…, 0101…, a lone most significant bit, a run of ones below the most significant bit, and all ones except bit 0.
- R9: The product is exact for an odd `WIDTH` as well. The row count is floor((WIDTH+3)/2), so the topmost window always recodes to a non-negative digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| in_x | input | WIDTH | Multiplier operand, recoded in windows |
| in_y | input | WIDTH | Multiplicand operand, selected as ±1 or ±2 multiples |
| out_valid | output | 1 | Product register holds a new result |
| out_p | output | 2*WIDTH | Registered product |

## Verification
The bench builds two copies of the block. The first uses WIDTH=16. It gets directed multipliers that force every digit code, including the -2 and -1 cases that rely on the inverted rows and the correction vector, followed by a few hundred random pairs. The second copy uses WIDTH=5, an odd width with a 10-bit product, and it receives all 1024 operand pairs. That brings the extra top row and the wrap of the sign constant fully within reach. Idle cycles between results check that the register holds its value, and a reset in the middle of the run checks that it clears.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Per-row selection controls produced by the recoder
  typedef struct packed {
    logic one;   // pick the multiplicand
    logic two;   // pick twice the multiplicand
    logic neg;   // invert the pick; +1 goes to the correction vector
  } booth_ctl_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0]  grp,
  output booth_ctl_t  ctl
);

  // grp = {upper, middle, lower} bits of a window
  always_comb begin
    ctl = '0;
    case (grp)
      3'b001, 3'b010: ctl.one = 1'b1;
      3'b011:         ctl.two = 1'b1;
      3'b100: begin
        ctl.two = 1'b1;
        ctl.neg = 1'b1;
      end
      3'b101, 3'b110: begin
        ctl.one = 1'b1;
        ctl.neg = 1'b1;
      end
      default: ctl = '0; // 000 and 111 select zero, never negated
    endcase
  end

endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int PW    = 32,
  parameter int IDX   = 0
) (
  input  logic [2:0]       grp,
  input  logic [WIDTH-1:0] mcand,
  output logic [PW-1:0]    row,
  output logic             neg
);

  localparam int SH = 2 * IDX;

  booth_ctl_t       ctl;
  logic [WIDTH+1:0] y_ext;   // multiplicand with a zero below and above
  logic [WIDTH:0]   pick;    // selected multiple, inverted when negative
  logic [WIDTH+1:0] ext;     // pick plus the inverted sign bit

  booth_recoder u_rec (
    .grp (grp),
    .ctl (ctl)
  );

  assign y_ext = {1'b0, mcand, 1'b0};

  for (genvar j = 0; j <= WIDTH; j++) begin : g_sel
    assign pick[j] = ((ctl.one & y_ext[j+1]) | (ctl.two & y_ext[j])) ^ ctl.neg;
  end

  // The sign run is replaced by ~sign here; the remaining -2^(WIDTH+1)
  // of every row is merged into one constant at the top level.
  assign ext = {~ctl.neg, pick};
  assign neg = ctl.neg;

  if (SH < PW) begin : g_place
    assign row = PW'(ext) << SH;
  end else begin : g_drop
    assign row = '0;
  end

endmodule

// File: rtl/booth_csa_sum.sv
module booth_csa_sum #(
  parameter int OPS = 11,
  parameter int W   = 32
) (
  input  logic [OPS-1:0][W-1:0] ops,
  output logic [W-1:0]          total
);

  logic [W-1:0] s_acc;
  logic [W-1:0] c_acc;
  logic [W-1:0] s_old;

  // Linear chain of 3:2 compressors keeping a redundant sum/carry pair
  always_comb begin
    s_acc = '0;
    c_acc = '0;
    s_old = '0;
    for (int k = 0; k < OPS; k++) begin
      s_old = s_acc;
      s_acc = s_old ^ c_acc ^ ops[k];
      c_acc = ((s_old & c_acc) | (s_old & ops[k]) | (c_acc & ops[k])) << 1;
    end
  end

  // Single carry-propagate stage
  assign total = s_acc + c_acc;

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WIDTH-1:0]     in_x,
  input  logic [WIDTH-1:0]     in_y,
  output logic                 out_valid,
  output logic [2*WIDTH-1:0]   out_p
);

  localparam int PW   = 2 * WIDTH;
  localparam int ROWS = (WIDTH + 3) / 2;
  localparam int XW   = 2 * ROWS + 1;
  localparam int OPS  = ROWS + 2;

  // Sum of every row's -2^(WIDTH+1) offset, taken modulo 2^PW
  function automatic logic [PW-1:0] sign_const();
    logic [PW-1:0] k;
    k = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (WIDTH + 1 + 2 * i < PW) k = k - (PW'(1) << (WIDTH + 1 + 2 * i));
    end
    return k;
  endfunction

  localparam logic [PW-1:0] SIGN_K = sign_const();

  logic [XW-1:0]          x_ext;
  logic [OPS-1:0][PW-1:0] ops;
  logic [ROWS-1:0]        negs;
  logic [PW-1:0]          corr;
  logic [PW-1:0]          prod;

  // zero below bit 0, zero padding above the top bit
  assign x_ext = XW'({in_x, 1'b0});

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    booth_pp_row #(
      .WIDTH (WIDTH),
      .PW    (PW),
      .IDX   (i)
    ) u_row (
      .grp   (x_ext[2*i+2:2*i]),
      .mcand (in_y),
      .row   (ops[i]),
      .neg   (negs[i])
    );
  end

  // +1 of each negated row, placed at that row's least significant column
  for (genvar b = 0; b < PW; b++) begin : g_corr
    if ((b % 2 == 0) && (b / 2 < ROWS)) begin : g_hit
      assign corr[b] = negs[b/2];
    end else begin : g_zero
      assign corr[b] = 1'b0;
    end
  end

  assign ops[ROWS]   = corr;
  assign ops[ROWS+1] = SIGN_K;

  booth_csa_sum #(
    .OPS (OPS),
    .W   (PW)
  ) u_sum (
    .ops   (ops),
    .total (prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_p     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_p <= prod;
    end
  end

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [WIDTH-1:0]   in_x,
  input logic [WIDTH-1:0]   in_y,
  input logic               out_valid,
  input logic [2*WIDTH-1:0] out_p
);

  localparam int PW = 2 * WIDTH;

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_p == (PW'($past(in_x)) * PW'($past(in_y))));

  p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      p_reset_r3: assert (out_valid == 1'b0 && out_p == '0);
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_p));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_x == '0) |=> out_p == '0);

  p_ident_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_y == WIDTH'(1)) |=> out_p == PW'($past(in_x)));

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_x      (in_x),
  .in_y      (in_y),
  .out_valid (out_valid),
  .out_p     (out_p)
);

// File: tb/booth_mult_bench.sv
`timescale 1ns/1ps
module booth_mult_bench;

  localparam int W   = 16;
  localparam int PW  = 32;
  localparam int SW  = 5;
  localparam int SPW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [W-1:0]  in_x = '0, in_y = '0;
  logic          out_valid;
  logic [PW-1:0] out_p;

  logic          s_valid = 1'b0;
  logic [SW-1:0] s_x = '0, s_y = '0;
  logic          s_ov;
  logic [SPW-1:0] s_p;

  booth_mult #(.WIDTH(W)) u_booth_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_p(out_p)
  );

  booth_mult #(.WIDTH(SW)) u_booth_mult_odd (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_x(s_x), .in_y(s_y),
    .out_valid(s_ov), .out_p(s_p)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [PW-1:0]  exp_q[$];
  string          tag_q[$];
  logic [SPW-1:0] sexp_q[$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: present operands and push the expected product
  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, string tag);
    logic [63:0] full;
    @(negedge clk);
    in_valid = 1'b1;
    in_x = x;
    in_y = y;
    full = 64'(x) * 64'(y);
    exp_q.push_back(PW'(full));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor for the wide instance
  logic [PW-1:0] last_p;
  bit            last_ok = 1'b0;
  logic [PW-1:0] e_val;
  string         e_tag;
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected valid", 64'd1, 64'd0);
        end else begin
          e_val = exp_q.pop_front();
          e_tag = tag_q.pop_front();
          check(e_tag, 64'(out_p), 64'(e_val));
        end
      end else if (last_ok) begin
        check("R4 hold", 64'(out_p), 64'(last_p));
      end
      last_p  = out_p;
      last_ok = 1'b1;
    end else begin
      last_ok = 1'b0;
    end
  end

  // monitor for the odd-width instance
  logic [SPW-1:0] se_val;
  always @(negedge clk) begin
    if (!rst && s_ov) begin
      if (sexp_q.size() == 0) begin
        check("R9 unexpected valid", 64'd1, 64'd0);
      end else begin
        se_val = sexp_q.pop_front();
        check("R9 odd width", 64'(s_p), 64'(se_val));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reset valid", 64'(out_valid), 64'd0);
    check("R3 reset product", 64'(out_p), 64'd0);
    @(posedge clk);
    #1 rst = 1'b0;

    drive(16'h0000, 16'hBEEF, "R5 zero multiplier");
    drive(16'h0000, 16'hFFFF, "R5 zero multiplier");
    drive(16'h1234, 16'h0001, "R6 unit multiplicand");
    drive(16'hFFFF, 16'h0001, "R6 unit multiplicand");
    drive(16'hFFFF, 16'hFFFF, "R7 all ones");
    drive(16'hAAAA, 16'hFFFF, "R8 alternating 1010");
    drive(16'h5555, 16'hABCD, "R8 alternating 0101");
    drive(16'h8000, 16'hFFFF, "R8 lone msb");
    drive(16'h7FFF, 16'h8001, "R8 run below msb");
    drive(16'hFFFE, 16'h0003, "R8 ones except bit0");
    drive(16'h0001, 16'h0001, "R1 one by one");
    idle(3);
    for (int k = 0; k < 300; k++) begin
      drive(W'($urandom), W'($urandom), "R1 random");
      if (k % 7 == 3) idle(1);
    end
    idle(3);

    // reset in the middle of the run clears the register
    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3 mid-run valid", 64'(out_valid), 64'd0);
    check("R3 mid-run product", 64'(out_p), 64'd0);
    @(posedge clk);
    #1 rst = 1'b0;

    for (int x = 0; x < (1 << SW); x++) begin
      for (int y = 0; y < (1 << SW); y++) begin
        @(negedge clk);
        s_valid = 1'b1;
        s_x = SW'(x);
        s_y = SW'(y);
        sexp_q.push_back(SPW'(x * y));
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    idle(4);

    check("R2 queue drained", 64'(exp_q.size()), 64'd0);
    check("R9 queue drained", 64'(sexp_q.size()), 64'd0);
    finish_run();
  end

endmodule